// File: doc/BRIEF.md
# 16-bit Legacy Bus Bridge for a Sizing 32-bit Processor

This block sits between a 32-bit processor that supports dynamic bus sizing and an older 16-bit asynchronous bus. It turns the processor's transfer size and address bit 0 into upper and lower byte strobes, and gates them with the processor data strobe. It routes the 16-bit bus onto the processor's upper data lanes and passes address lines 23:1 straight through.

The bridge acknowledges every cycle as a 16-bit port cycle. The processor then splits wider transfers into 16-bit pieces by itself. The bridge also signals autovectored interrupts during interrupt-acknowledge cycles. For slow synchronous peripherals it generates a free-running E clock and a valid-memory-address qualifier. A build option inverts the clock fed to the processor. This suits systems whose timing expects the address strobe on the opposite clock edge.

All strobes and acknowledges are active-high inside this block. Level conversion to active-low pins is done at the chip pads.

Top module: `bus16_bridge`

## Requirements
- R1: `bus_wdata` equals `cpu_wdata_up`. `cpu_rdata[31:16]` equals `bus_rdata`, and `cpu_rdata[15:0]` reads zero.
- R2: `bus_addr[23:1]` equals `cpu_addr[23:1]`. `bus_as` follows `cpu_as` and `bus_rw` follows `cpu_rw` combinationally.
- R3: The size code is `cpu_siz` = 01 for a byte, 10 for a word, 11 for three bytes and 00 for a long. While `cpu_ds` is high, `bus_uds` is high exactly when `cpu_addr[0]` = 0. Under the same condition, `bus_lds` is high when `cpu_addr[0]` = 1 or when the size code is not 01.
- R4: Both byte strobes are low whenever `cpu_ds` is low, whatever the size code and address bit 0.
- R5: `cpu_dsack1` goes high one clock after a clock edge that sees `bus_dtack`, `cpu_as` and `cpu_ds` all high. It falls in the same cycle that `cpu_as` falls.
- R6: `cpu_dsack0` is low at all times.
- R7: `cpu_avec` is high exactly while `cpu_as` is high and `cpu_fc` = 111.
- R8: `bus_eclk` repeats every 10 clocks. It is low for 6 clocks and then high for 4, and it starts low after reset.
- R9: A request is `bus_vpa_sel` high together with `cpu_as`. After a request, `bus_vma` rises on the clock where `bus_eclk` next falls. It then stays high for exactly one E period (10 clocks) and falls together with the following fall of `bus_eclk`.
- R10: `cpu_clk` equals `clk` when `INVERT_CLK` = 0 and equals the inverse of `clk` when `INVERT_CLK` = 1.
- R11: While `rst_n` is low, `cpu_dsack1`, `bus_vma` and `bus_eclk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_clk | output | 1 | Clock to the processor, optionally inverted |
| cpu_addr | input | 24 | Processor address lines 23:0 (bits 31:24 not brought in) |
| cpu_as | input | 1 | Processor address strobe |
| cpu_ds | input | 1 | Processor data strobe |
| cpu_rw | input | 1 | Processor read (1) / write (0) |
| cpu_siz | input | 2 | Transfer size code |
| cpu_fc | input | 3 | Function code lines |
| cpu_wdata_up | input | 16 | Processor write data, lanes 31:16 |
| cpu_rdata | output | 32 | Read data to processor |
| cpu_dsack1 | output | 1 | 16-bit port acknowledge |
| cpu_dsack0 | output | 1 | 8-bit port acknowledge, held low |
| cpu_avec | output | 1 | Autovector request |
| bus_addr | output | 23 | Legacy address lines 23:1 |
| bus_as | output | 1 | Legacy address strobe |
| bus_rw | output | 1 | Legacy read/write |
| bus_uds | output | 1 | Upper byte strobe |
| bus_lds | output | 1 | Lower byte strobe |
| bus_wdata | output | 16 | Legacy write data |
| bus_rdata | input | 16 | Legacy read data |
| bus_dtack | input | 1 | Legacy data acknowledge |
| bus_vpa_sel | input | 1 | Valid-peripheral-address request |
| bus_eclk | output | 1 | Slow peripheral E clock |
| bus_vma | output | 1 | Valid memory address qualifier |

## Verification
The assertions assume that the processor keeps `cpu_as` high for a whole cycle. They also assume that `bus_dtack` and `bus_vpa_sel` change only between clock edges, and that a peripheral request is withdrawn by the time its VMA window closes. Otherwise a held request would open a second window, which is legal but not what the window-length property expects. The bench drives every input half a clock away from the sampling edge. It drops the address strobe and the request once `bus_vma` has risen, and it raises `bus_dtack` only inside an active strobe.

// File: rtl/bridge_pkg.sv
// Package: shared size codes and E clock defaults for the 16-bit bus bridge.
// Assumes the processor's two-bit transfer size encoding given in the brief.
package bridge_pkg;
    typedef enum logic [1:0] {
        SZ_LONG  = 2'b00,
        SZ_BYTE  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_TRIPLE = 2'b11
    } xfer_size_e;

    localparam int unsigned E_DIV_DEF = 10;
    localparam int unsigned E_LOW_DEF = 6;
    localparam logic [2:0]  FC_IACK   = 3'b111;
endpackage

// File: rtl/lane_decode.sv
// Module: lane_decode
// Maps the 16-bit bus onto the processor's upper data lanes and passes the
// address through. It also decodes size and address bit 0 into byte strobes.
// Assumes the processor services a 16-bit port on lanes CPU_DW-1 downto
// CPU_DW-BUS_DW.
module lane_decode
    import bridge_pkg::*;
#(
    parameter int unsigned CPU_DW = 32,
    parameter int unsigned BUS_DW = 16,
    parameter int unsigned BUS_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] cpu_addr,
    input  logic              cpu_ds,
    input  logic [1:0]        cpu_siz,
    input  logic [BUS_DW-1:0] cpu_wdata_up,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic [BUS_AW-1:1] bus_addr,
    output logic [BUS_DW-1:0] bus_wdata,
    input  logic [BUS_DW-1:0] bus_rdata,
    output logic              bus_uds,
    output logic              bus_lds
);
    localparam int unsigned LANE_OFS = CPU_DW - BUS_DW;

    // Lane routing: the bus sits on the upper lanes; lower lanes read zero.
    genvar gi;
    generate
        for (gi = 0; gi < BUS_DW; gi++) begin : g_up
            assign bus_wdata[gi]           = cpu_wdata_up[gi];
            assign cpu_rdata[gi+LANE_OFS]  = bus_rdata[gi];
        end
        for (gi = 0; gi < LANE_OFS; gi++) begin : g_lo
            assign cpu_rdata[gi] = 1'b0;
        end
    endgenerate

    // Address pass-through for lines above bit 0.
    assign bus_addr = cpu_addr[BUS_AW-1:1];

    // Byte strobe decode, qualified by the data strobe.
    always_comb begin
        bus_uds = cpu_ds & ~cpu_addr[0];
        bus_lds = cpu_ds & (cpu_addr[0] | (cpu_siz != SZ_BYTE));
    end

    // R3: a byte transfer drives exactly one lane.
    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ds && cpu_siz == SZ_BYTE) |-> $countones({bus_uds, bus_lds}) == 1);

    // R4: no lane is strobed without the data strobe.
    p_no_strobe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ds |-> !(bus_uds || bus_lds));
endmodule

// File: rtl/port_ack.sv
// Module: port_ack
// Converts the legacy data acknowledge into a 16-bit port acknowledge.
// It also raises the autovector request in interrupt-acknowledge cycles.
// Assumes bus_dtack is only raised inside an active strobe.
module port_ack
    import bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_as,
    input  logic       cpu_ds,
    input  logic [2:0] cpu_fc,
    input  logic       bus_dtack,
    output logic       cpu_dsack1,
    output logic       cpu_dsack0,
    output logic       cpu_avec
);
    logic ack_q;

    // Register the acknowledge seen during an active strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= cpu_as & cpu_ds & bus_dtack;
    end

    // Drop the acknowledge at once when the address strobe goes away.
    assign cpu_dsack1 = ack_q & cpu_as;
    assign cpu_dsack0 = 1'b0;

    // Autovector in interrupt-acknowledge space.
    assign cpu_avec = cpu_as & (cpu_fc == FC_IACK);

    // R5: a rising acknowledge was caused by the legacy acknowledge.
    p_ack_from_dtack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_dsack1) |-> $past(bus_dtack));
endmodule

// File: rtl/eclk_gen.sv
// Module: eclk_gen
// Generates the free-running E clock for slow peripherals and the VMA
// qualifier that covers one whole E period.
// Assumes that a request is withdrawn before its VMA window ends.
module eclk_gen #(
    parameter int unsigned E_DIV = 10,
    parameter int unsigned E_LOW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    output logic eclk,
    output logic vma
);
    localparam int unsigned CNT_W = $clog2(E_DIV);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(E_DIV - 1);
    localparam logic [CNT_W-1:0] LOW_N = CNT_W'(E_LOW);
    localparam logic [CNT_W-1:0] HI_N  = CNT_W'(E_DIV - E_LOW);

    logic [CNT_W-1:0] ecnt;
    logic             req_q;
    logic             wrap;
    logic             pend;

    assign wrap = (ecnt == LAST);
    assign pend = req_q | req_in;
    assign eclk = (ecnt >= LOW_N);

    // Free-running phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    ecnt <= '0;
        else if (wrap) ecnt <= '0;
        else           ecnt <= ecnt + 1'b1;
    end

    // Hold a request until the next E low phase starts.
    always_ff @(posedge clk) begin
        if (!rst_n)            req_q <= 1'b0;
        else if (vma)          req_q <= 1'b0;
        else if (wrap)         req_q <= 1'b0;
        else                   req_q <= pend;
    end

    // Open the window on E fall, close it on the following E fall.
    always_ff @(posedge clk) begin
        if (!rst_n)            vma <= 1'b0;
        else if (wrap && vma)  vma <= 1'b0;
        else if (wrap && pend) vma <= 1'b1;
    end

    // Count high and low phase lengths for the checks below.
    logic [CNT_W-1:0] hi_len, lo_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            hi_len <= eclk ? hi_len + 1'b1 : '0;
            lo_len <= eclk ? '0 : lo_len + 1'b1;
        end
    end

    // R8: the high phase has its full length.
    p_e_high_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eclk) |-> hi_len == HI_N);
    // R8: the low phase has its full length.
    p_e_low_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eclk) |-> lo_len == LOW_N);
    // R9: VMA opens on an E fall.
    p_vma_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vma) |-> $fell(eclk));
    // R9: VMA closes on an E fall.
    p_vma_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vma) |-> $fell(eclk));
endmodule

// File: rtl/bus16_bridge.sv
// Module: bus16_bridge (top)
// Bridges a 32-bit processor with dynamic bus sizing onto a 16-bit
// asynchronous bus. It routes lanes and strobes, acknowledges every cycle
// as a 16-bit port, and drives E/VMA. Assumes active-high signalling inside
// the block.
module bus16_bridge
    import bridge_pkg::*;
#(
    parameter int unsigned CPU_DW     = 32,
    parameter int unsigned BUS_DW     = 16,
    parameter int unsigned BUS_AW     = 24,
    parameter int unsigned E_DIV      = E_DIV_DEF,
    parameter int unsigned E_LOW      = E_LOW_DEF,
    parameter bit          INVERT_CLK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cpu_clk,
    input  logic [BUS_AW-1:0] cpu_addr,
    input  logic              cpu_as,
    input  logic              cpu_ds,
    input  logic              cpu_rw,
    input  logic [1:0]        cpu_siz,
    input  logic [2:0]        cpu_fc,
    input  logic [BUS_DW-1:0] cpu_wdata_up,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic              cpu_dsack1,
    output logic              cpu_dsack0,
    output logic              cpu_avec,
    output logic [BUS_AW-1:1] bus_addr,
    output logic              bus_as,
    output logic              bus_rw,
    output logic              bus_uds,
    output logic              bus_lds,
    output logic [BUS_DW-1:0] bus_wdata,
    input  logic [BUS_DW-1:0] bus_rdata,
    input  logic              bus_dtack,
    input  logic              bus_vpa_sel,
    output logic              bus_eclk,
    output logic              bus_vma
);
    // Processor clock, inverted when the build option asks for it.
    generate
        if (INVERT_CLK) begin : g_inv
            assign cpu_clk = ~clk;
        end else begin : g_pass
            assign cpu_clk = clk;
        end
    endgenerate

    // Control pass-through.
    assign bus_as = cpu_as;
    assign bus_rw = cpu_rw;

    lane_decode #(
        .CPU_DW(CPU_DW), .BUS_DW(BUS_DW), .BUS_AW(BUS_AW)
    ) lanes_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_ds(cpu_ds), .cpu_siz(cpu_siz),
        .cpu_wdata_up(cpu_wdata_up), .cpu_rdata(cpu_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_uds(bus_uds), .bus_lds(bus_lds)
    );

    port_ack ack_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_as(cpu_as), .cpu_ds(cpu_ds), .cpu_fc(cpu_fc),
        .bus_dtack(bus_dtack),
        .cpu_dsack1(cpu_dsack1), .cpu_dsack0(cpu_dsack0), .cpu_avec(cpu_avec)
    );

    eclk_gen #(
        .E_DIV(E_DIV), .E_LOW(E_LOW)
    ) eclk_i (
        .clk(clk), .rst_n(rst_n),
        .req_in(bus_vpa_sel & cpu_as),
        .eclk(bus_eclk), .vma(bus_vma)
    );
endmodule

// File: tb/bus16_bridge_tb_top.sv
`timescale 1ns/1ps
module bus16_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_as = 1'b0, cpu_ds = 1'b0, cpu_rw = 1'b1;
    logic [1:0]  cpu_siz = 2'b00;
    logic [2:0]  cpu_fc = 3'b001;
    logic [15:0] cpu_wdata_up = '0;
    logic [15:0] bus_rdata = '0;
    logic        bus_dtack = 1'b0, bus_vpa_sel = 1'b0;
    logic        cpu_clk, cpu_clk_inv;
    logic [31:0] cpu_rdata, rd_unused;
    logic        cpu_dsack1, cpu_dsack0, cpu_avec;
    logic [23:1] bus_addr, a_unused;
    logic        bus_as, bus_rw, bus_uds, bus_lds, bus_eclk, bus_vma;
    logic [15:0] bus_wdata, wd_unused;
    logic        u1, u2, u3, u4, u5, u6, u7, u8, u9, u10;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bus16_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk),
        .cpu_addr(cpu_addr), .cpu_as(cpu_as), .cpu_ds(cpu_ds), .cpu_rw(cpu_rw),
        .cpu_siz(cpu_siz), .cpu_fc(cpu_fc), .cpu_wdata_up(cpu_wdata_up),
        .cpu_rdata(cpu_rdata), .cpu_dsack1(cpu_dsack1), .cpu_dsack0(cpu_dsack0),
        .cpu_avec(cpu_avec), .bus_addr(bus_addr), .bus_as(bus_as), .bus_rw(bus_rw),
        .bus_uds(bus_uds), .bus_lds(bus_lds), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_dtack(bus_dtack), .bus_vpa_sel(bus_vpa_sel),
        .bus_eclk(bus_eclk), .bus_vma(bus_vma)
    );

    // Second copy built with the inverted processor clock (R10).
    bus16_bridge #(.INVERT_CLK(1'b1)) inv_i (
        .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk_inv),
        .cpu_addr(cpu_addr), .cpu_as(1'b0), .cpu_ds(1'b0), .cpu_rw(1'b1),
        .cpu_siz(2'b00), .cpu_fc(3'b000), .cpu_wdata_up(16'h0),
        .cpu_rdata(rd_unused), .cpu_dsack1(u1), .cpu_dsack0(u2),
        .cpu_avec(u3), .bus_addr(a_unused), .bus_as(u4), .bus_rw(u5),
        .bus_uds(u6), .bus_lds(u7), .bus_wdata(wd_unused),
        .bus_rdata(16'h0), .bus_dtack(1'b0), .bus_vpa_sel(1'b0),
        .bus_eclk(u8), .bus_vma(u9)
    );
    assign u10 = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Strobe vectors {ds, siz[1:0], a0, exp_uds, exp_lds} for R3 and R4.
    localparam logic [5:0] STB_VEC [12] = '{
        6'b1_01_0_10, 6'b1_01_1_01, 6'b1_10_0_11, 6'b1_10_1_01,
        6'b1_11_0_11, 6'b1_11_1_01, 6'b1_00_0_11, 6'b1_00_1_01,
        6'b0_00_0_00, 6'b0_10_1_00, 6'b0_11_0_00, 6'b0_01_1_00
    };

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lo_cnt, hi_cnt, vma_len;
        logic prev_e;
        // R11 reset state
        repeat (3) @(negedge clk);
        check(cpu_dsack1 == 0, "R11", "dsack1 in reset", cpu_dsack1, 0);
        check(bus_vma == 0,    "R11", "vma in reset",    bus_vma, 0);
        check(bus_eclk == 0,   "R11", "eclk in reset",   bus_eclk, 0);
        rst_n = 1'b1;

        // R3 / R4 table walk
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cpu_as = 1'b1;
            cpu_ds = STB_VEC[i][5];
            cpu_siz = STB_VEC[i][4:3];
            cpu_addr[0] = STB_VEC[i][2];
            #1;
            check({bus_uds, bus_lds} == STB_VEC[i][1:0],
                  STB_VEC[i][5] ? "R3" : "R4", "strobes",
                  {30'b0, bus_uds, bus_lds}, {30'b0, STB_VEC[i][1:0]});
        end

        // R1 / R2 lanes and address
        @(negedge clk);
        cpu_addr = 24'hA5_C3_97; cpu_wdata_up = 16'hBEEF; bus_rdata = 16'h1234;
        cpu_rw = 1'b0;
        #1;
        check(bus_wdata == 16'hBEEF, "R1", "write lanes", bus_wdata, 32'hBEEF);
        check(cpu_rdata == 32'h1234_0000, "R1", "read lanes", cpu_rdata, 32'h1234_0000);
        check(bus_addr == 23'h52_E1CB, "R2", "address", bus_addr, 23'h52_E1CB);
        check(bus_as == 1 && bus_rw == 0, "R2", "as/rw pass",
              {bus_as, bus_rw}, 32'b10);

        // R5 handshake
        @(negedge clk);
        cpu_as = 1; cpu_ds = 1; bus_dtack = 0;
        @(negedge clk);
        check(cpu_dsack1 == 0, "R5", "no ack before dtack", cpu_dsack1, 0);
        bus_dtack = 1;
        @(negedge clk);
        check(cpu_dsack1 == 1, "R5", "ack one clock after dtack", cpu_dsack1, 1);
        check(cpu_dsack0 == 0, "R6", "dsack0 during ack", cpu_dsack0, 0);
        cpu_as = 0; cpu_ds = 0;
        #1;
        check(cpu_dsack1 == 0, "R5", "ack drops with as", cpu_dsack1, 0);
        bus_dtack = 0;

        // R7 autovector
        @(negedge clk);
        cpu_as = 1; cpu_fc = 3'b111; #1;
        check(cpu_avec == 1, "R7", "avec in iack", cpu_avec, 1);
        cpu_fc = 3'b110; #1;
        check(cpu_avec == 0, "R7", "no avec fc=110", cpu_avec, 0);
        cpu_fc = 3'b111; cpu_as = 0; #1;
        check(cpu_avec == 0, "R7", "no avec without as", cpu_avec, 0);
        cpu_fc = 3'b001;

        // R10 clock option, sampled on both phases
        @(negedge clk); #0.5;
        check(cpu_clk == 0 && cpu_clk_inv == 1, "R10", "clk low phase",
              {cpu_clk, cpu_clk_inv}, 32'b01);
        @(posedge clk); #0.5;
        check(cpu_clk == 1 && cpu_clk_inv == 0, "R10", "clk high phase",
              {cpu_clk, cpu_clk_inv}, 32'b10);

        // R8 E duty cycle
        @(negedge clk); prev_e = bus_eclk;
        forever begin
            @(negedge clk);
            if (!prev_e && bus_eclk) break;
            prev_e = bus_eclk;
        end
        hi_cnt = 0;
        while (bus_eclk) begin hi_cnt++; @(negedge clk); end
        lo_cnt = 0;
        while (!bus_eclk) begin lo_cnt++; @(negedge clk); end
        check(hi_cnt == 4, "R8", "E high length", hi_cnt, 4);
        check(lo_cnt == 6, "R8", "E low length", lo_cnt, 6);

        // R9 VMA window, request placed mid high phase
        check(bus_vma == 0, "R9", "vma idle", bus_vma, 0);
        @(negedge clk);
        cpu_as = 1; bus_vpa_sel = 1;
        prev_e = bus_eclk;
        forever begin
            @(negedge clk);
            if (prev_e && !bus_eclk) break;
            check(bus_vma == 0, "R9", "vma before E fall", bus_vma, 0);
            prev_e = bus_eclk;
        end
        check(bus_vma == 1, "R9", "vma at E fall", bus_vma, 1);
        cpu_as = 0; bus_vpa_sel = 0;
        vma_len = 0;
        while (bus_vma && vma_len < 40) begin
            vma_len++; prev_e = bus_eclk; @(negedge clk);
        end
        check(vma_len == 10, "R9", "vma length", vma_len, 10);
        check(prev_e == 1 && bus_eclk == 0, "R9", "vma closes on E fall",
              {prev_e, bus_eclk}, 32'b10);
        repeat (12) @(negedge clk);
        check(bus_vma == 0, "R9", "vma stays off", bus_vma, 0);
        check(cpu_dsack0 == 0, "R6", "dsack0 idle", cpu_dsack0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule